// File: doc/BRIEF.md
# Register-Access Serial Port Slave

This block lets a host read and write an internal register file over a serial link made of a chip select, a serial clock and a data line. Every transaction opens with an 8-bit instruction. The instruction chooses read or write and names a register. A data phase follows, and its length is the byte width of the addressed register. The block derives that length itself, so the host sends or receives exactly that many bytes. Once the last data bit has passed, the next eight rising serial-clock edges form the instruction of a new transaction, and chip select does not need to toggle in between.

The block runs in one of two pin arrangements. In the 3-wire arrangement, read data leaves on a dedicated output. In the 2-wire arrangement, read data is driven back on the shared data line during the data phase. The serial clock may idle low or idle high. The block oversamples the serial pins with its own system clock and works in that clock domain only.

On the register side, the block gives the register address, a one-cycle write strobe carrying the whole assembled value, and a one-cycle fetch strobe. During the fetch strobe the register file presents the value to be read.

Top module: `regport_serial_slave`

## Requirements
- R1: Instruction bits arrive most significant first. Bit 7 set means a read and bit 7 clear means a write. Bits 4:0 are the register address on `rf_addr`. Bits 6:5 have no effect.
- R2: The data phase lasts a fixed number of bytes for each address: 4 for addresses 0 and 1, 3 for address 2, 6 for addresses 3 and 5, 2 for address 4, and 1 for every other address.
- R3: A write raises `rf_wr_en` for exactly one clock, after the rising edge of its final data bit. `rf_wr_data` holds the received bits most significant first, right-aligned, with every bit above the register width at zero.
- R4: A read raises `rf_rd_en` for exactly one clock, after the eighth instruction bit. The value on `rf_rd_data` in that cycle is shifted out most significant first, starting at bit (width×8−1). Bus bits above the register width are not sent.
- R5: With `two_wire_mode` low, read bits appear on `sdo_o` with `sdo_oe` high during the data phase, and `sdio_oe` stays low.
- R6: With `two_wire_mode` high, read bits appear on `sdio_o` with `sdio_oe` high during the data phase, and `sdo_oe` stays low.
- R7: Both output enables are low after reset, during instruction phases, during write data, after a transaction ends, and within a few clocks of `cs_n` going high.
- R8: Without `cs_n` going high, the eight rising edges after a transaction's last data bit are decoded as a new instruction.
- R9: Raising `cs_n` at any point abandons the transaction without a write strobe. The next frame starts with a fresh instruction phase.
- R10: Input bits are taken on rising serial-clock edges and read bits are launched on falling edges. Operation is the same whether the serial clock idles low or high, given high and low times of at least 4 clock periods each.
- R11: Addresses above 5 read back as zero regardless of `rf_rd_data`, and writes to them raise no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| two_wire_mode | input | 1 | 1: read data on the shared line; 0: read data on the dedicated output |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| sdio_i | input | 1 | Shared data line, input side |
| sdio_o | output | 1 | Shared data line, output side (2-wire reads) |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| sdo_o | output | 1 | Dedicated serial data output (3-wire reads) |
| sdo_oe | output | 1 | Drive enable for the dedicated output |
| rf_addr | output | 5 | Register address from the current instruction |
| rf_wr_en | output | 1 | One-cycle write strobe |
| rf_wr_data | output | 48 | Assembled write value, right-aligned |
| rf_rd_en | output | 1 | One-cycle fetch strobe for a read |
| rf_rd_data | input | 48 | Register value presented during the fetch strobe |

## Verification
Writes and reads cover every data length: 2, 3, 4 and 6 bytes, plus 1 byte for undefined addresses. A length error therefore shows up as shifted or truncated data, or as a missing strobe. The register-file model fills the bus bits above each register's width with a fixed pattern, and for undefined addresses it returns a nonzero pattern. This separates correct alignment and zeroing from plain pass-through. Transactions run both one per frame and back to back within a frame, in both pin arrangements and with both clock idle levels, so a framing error cannot hide behind chip-select resynchronisation. A write and a read are each cut short by chip select, which shows whether abort suppresses the commit and releases the output drivers.

// File: rtl/regport_pkg.sv
package regport_pkg;
  localparam int ADDR_W    = 5;
  localparam int MAX_BYTES = 6;
  localparam int NUM_REGS  = 6;
  localparam int BYTE_W    = $clog2(MAX_BYTES) + 1;
  localparam int DATA_W    = MAX_BYTES * 8;
  localparam int INSTR_W   = 8;

  typedef enum logic {
    PH_INSTR = 1'b0,
    PH_DATA  = 1'b1
  } phase_e;

  // Byte width of each register; unmapped addresses take one byte.
  function automatic logic [BYTE_W-1:0] reg_bytes(input logic [ADDR_W-1:0] a);
    case (int'(a))
      0, 1:    return BYTE_W'(4);
      2:       return BYTE_W'(3);
      3, 5:    return BYTE_W'(6);
      4:       return BYTE_W'(2);
      default: return BYTE_W'(1);
    endcase
  endfunction

  function automatic logic reg_defined(input logic [ADDR_W-1:0] a);
    return int'(a) < NUM_REGS;
  endfunction
endpackage

// File: rtl/regport_sync.sv
module regport_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/regport_front.sv
module regport_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic sdio_i,
  output logic cs_act,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic sdi
);
  localparam int PINS = 3;

  logic [PINS-1:0] pins_s;
  logic            sclk_prev_q;

  // Chip select, clock and data share one chain so they stay aligned.
  regport_sync #(
    .WIDTH  (PINS),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({cs_n, sclk, sdio_i}),
    .dout (pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= pins_s[1];
  end

  assign cs_act    = ~pins_s[2];
  assign sclk_rise = pins_s[1] & ~sclk_prev_q;
  assign sclk_fall = ~pins_s[1] & sclk_prev_q;
  assign sdi       = pins_s[0];
endmodule

// File: rtl/regport_ctrl.sv
module regport_ctrl
  import regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdi,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic [ADDR_W-1:0] rf_addr,
  output logic              rf_wr_en,
  output logic [DATA_W-1:0] rf_wr_data,
  output logic              rf_rd_en,
  output logic              drv_en,
  output logic              drv_bit
);
  localparam int BIT_W = $clog2(INSTR_W);

  phase_e              ph_q, ph_d;
  logic [BIT_W-1:0]    bit_q, bit_d;
  logic [BYTE_W-1:0]   byte_q, byte_d;
  logic [INSTR_W-1:0]  ins_q, ins_d;
  logic [DATA_W-1:0]   sh_q, sh_d;
  logic                wr_q, wr_d;
  logic                fetch_q, fetch_d;
  logic                drv_q, drv_d;
  logic                dbit_q, dbit_d;

  logic [ADDR_W-1:0]   addr;
  logic                is_rd;
  logic                defd;
  logic [BYTE_W-1:0]   nbytes;
  logic                last_bit;
  logic                last_byte;

  assign addr      = ins_q[ADDR_W-1:0];
  assign is_rd     = ins_q[INSTR_W-1];
  assign defd      = reg_defined(addr);
  assign nbytes    = reg_bytes(addr);
  assign last_bit  = (bit_q == BIT_W'(INSTR_W - 1));
  assign last_byte = (byte_q == nbytes - BYTE_W'(1));

  always_comb begin
    ph_d    = ph_q;
    bit_d   = bit_q;
    byte_d  = byte_q;
    ins_d   = ins_q;
    sh_d    = sh_q;
    drv_d   = drv_q;
    dbit_d  = dbit_q;
    wr_d    = 1'b0;
    fetch_d = 1'b0;
    if (!cs_act) begin
      ph_d   = PH_INSTR;
      bit_d  = '0;
      byte_d = '0;
      drv_d  = 1'b0;
    end else begin
      if (fetch_q) begin
        // Left-align the fetched register so its top bit leaves first.
        sh_d = defd ? (rf_rd_data << (8 * (MAX_BYTES - int'(nbytes)))) : '0;
      end
      if (sclk_rise) begin
        bit_d = bit_q + BIT_W'(1);
        if (ph_q == PH_INSTR) begin
          ins_d = {ins_q[INSTR_W-2:0], sdi};
          if (last_bit) begin
            ph_d    = PH_DATA;
            byte_d  = '0;
            sh_d    = '0;
            fetch_d = ins_d[INSTR_W-1];
          end
        end else begin
          if (!is_rd) sh_d = {sh_q[DATA_W-2:0], sdi};
          if (last_bit) begin
            byte_d = byte_q + BYTE_W'(1);
            if (last_byte) begin
              ph_d   = PH_INSTR;
              byte_d = '0;
              drv_d  = 1'b0;
              wr_d   = !is_rd && defd;
            end
          end
        end
      end else if (sclk_fall && ph_q == PH_DATA && is_rd) begin
        dbit_d = sh_q[DATA_W-1];
        sh_d   = {sh_q[DATA_W-2:0], 1'b0};
        drv_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_INSTR;
      bit_q   <= '0;
      byte_q  <= '0;
      ins_q   <= '0;
      sh_q    <= '0;
      wr_q    <= 1'b0;
      fetch_q <= 1'b0;
      drv_q   <= 1'b0;
      dbit_q  <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
      ins_q   <= ins_d;
      sh_q    <= sh_d;
      wr_q    <= wr_d;
      fetch_q <= fetch_d;
      drv_q   <= drv_d;
      dbit_q  <= dbit_d;
    end
  end

  assign rf_addr    = addr;
  assign rf_wr_en   = wr_q;
  assign rf_wr_data = sh_q;
  assign rf_rd_en   = fetch_q;
  assign drv_en     = drv_q;
  assign drv_bit    = dbit_q;

  // R3: a commit is a single-cycle strobe
  p_wr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |=> !rf_wr_en);

  // R4: the fetch is a single-cycle strobe at the first data bit
  p_rd_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd_en |=> !rf_rd_en);

  p_rd_at_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd_en |-> (ph_q == PH_DATA && byte_q == '0 && bit_q == '0));

  // R2: the byte counter never passes the addressed register's width
  p_byte_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DATA) |-> (byte_q < nbytes));

  // R7: drivers are released once chip select is seen inactive
  p_release_on_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !drv_en);

  // R11: no strobe ever carries an unmapped address
  p_no_undef_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> reg_defined(rf_addr));
endmodule

// File: rtl/regport_serial_slave.sv
module regport_serial_slave
  import regport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              two_wire_mode,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe,
  output logic              sdo_o,
  output logic              sdo_oe,
  output logic [ADDR_W-1:0] rf_addr,
  output logic              rf_wr_en,
  output logic [DATA_W-1:0] rf_wr_data,
  output logic              rf_rd_en,
  input  logic [DATA_W-1:0] rf_rd_data
);
  logic rst_sync_n;
  logic cs_act, sclk_rise, sclk_fall, sdi;
  logic drv_en, drv_bit;

  regport_sync #(
    .WIDTH  (1),
    .STAGES (2),
    .RST_VAL(1'b0)
  ) u_rst_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (1'b1),
    .dout (rst_sync_n)
  );

  regport_front #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_front (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .sdio_i   (sdio_i),
    .cs_act   (cs_act),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .sdi      (sdi)
  );

  regport_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cs_act    (cs_act),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .sdi       (sdi),
    .rf_rd_data(rf_rd_data),
    .rf_addr   (rf_addr),
    .rf_wr_en  (rf_wr_en),
    .rf_wr_data(rf_wr_data),
    .rf_rd_en  (rf_rd_en),
    .drv_en    (drv_en),
    .drv_bit   (drv_bit)
  );

  // Steer read data to the pin set chosen by the wiring mode.
  always_comb begin
    sdio_oe = drv_en & two_wire_mode;
    sdio_o  = two_wire_mode ? drv_bit : 1'b0;
    sdo_oe  = drv_en & ~two_wire_mode;
    sdo_o   = two_wire_mode ? 1'b0 : drv_bit;
  end
endmodule

// File: tb/sim_regport_serial_slave.sv
module sim_regport_serial_slave;
  localparam int AW = 5;
  localparam int DW = 48;
  localparam int H  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic two_wire, sclk, cs_n, sdio_i;
  logic sdio_o, sdio_oe, sdo_o, sdo_oe;
  logic [AW-1:0] rf_addr;
  logic rf_wr_en, rf_rd_en;
  logic [DW-1:0] rf_wr_data, rf_rd_data;

  logic [DW-1:0] bmem [0:7];
  int checks = 0;
  int errors = 0;
  int rd_cnt = 0;
  logic [AW-1:0] qa [$];
  logic [DW-1:0] qd [$];
  logic [AW-1:0] ea;
  logic [DW-1:0] ed;

  function automatic int nbytes_of(input int a);
    case (a)
      0, 1:    return 4;
      2:       return 3;
      3, 5:    return 6;
      4:       return 2;
      default: return 1;
    endcase
  endfunction

  function automatic logic [DW-1:0] mask_of(input int n);
    if (n >= 6) return '1;
    return (48'd1 << (8 * n)) - 48'd1;
  endfunction

  // Register-file model: junk above each width, junk for unmapped addresses.
  assign rf_rd_data = (int'(rf_addr) < 6)
    ? (bmem[rf_addr[2:0]] | (~mask_of(nbytes_of(int'(rf_addr))) & 48'hA5A5_A5A5_A5A5))
    : 48'hDEAD_BEEF_CAFE;

  regport_serial_slave u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .two_wire_mode(two_wire),
    .sclk         (sclk),
    .cs_n         (cs_n),
    .sdio_i       (sdio_i),
    .sdio_o       (sdio_o),
    .sdio_oe      (sdio_oe),
    .sdo_o        (sdo_o),
    .sdo_oe       (sdo_oe),
    .rf_addr      (rf_addr),
    .rf_wr_en     (rf_wr_en),
    .rf_wr_data   (rf_wr_data),
    .rf_rd_en     (rf_rd_en),
    .rf_rd_data   (rf_rd_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected commits as write strobes appear.
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) bmem[i] = '0;
    end else begin
      if (rf_rd_en) rd_cnt++;
      if (rf_wr_en) begin
        if (qa.size() == 0) begin
          chk(1'b0, "R3/R9/R11", "unexpected write strobe", rf_wr_data, '0);
        end else begin
          ea = qa.pop_front();
          ed = qd.pop_front();
          chk(rf_addr == ea, "R1", "commit address", DW'(rf_addr), DW'(ea));
          chk(rf_wr_data == ed, "R3", "commit value", rf_wr_data, ed);
          bmem[ea[2:0]] = ed;
        end
      end
    end
  end

  // smp = {sdo_o, sdo_oe, sdio_o, sdio_oe}, taken just before the rising edge
  task automatic xfer_bit(input logic b, output logic [3:0] smp);
    sclk   = 1'b0;
    sdio_i = b;
    repeat (H) @(negedge clk);
    smp  = {sdo_o, sdo_oe, sdio_o, sdio_oe};
    sclk = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic frame_open(input bit idle_hi);
    sclk = idle_hi;
    repeat (H) @(negedge clk);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic frame_close(input bit idle_hi);
    sclk = idle_hi;
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * H) @(negedge clk);
    chk(!sdo_oe && !sdio_oe, "R7", "enables low after frame", DW'({sdo_oe, sdio_oe}), '0);
  endtask

  task automatic send_instr(input bit rd, input logic [1:0] pad, input logic [AW-1:0] a);
    logic [7:0] ib;
    logic [3:0] smp;
    bit oe_bad;
    ib = {rd, pad, a};
    oe_bad = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      xfer_bit(ib[i], smp);
      if (smp[2] || smp[0]) oe_bad = 1'b1;
    end
    chk(!oe_bad, "R7", "enables low in instruction", DW'(oe_bad), '0);
  endtask

  task automatic do_write(input logic [1:0] pad, input logic [AW-1:0] a,
                          input logic [DW-1:0] val);
    int n;
    logic [3:0] smp;
    bit oe_bad;
    n = nbytes_of(int'(a));
    if (int'(a) < 6) begin
      qa.push_back(a);
      qd.push_back(val & mask_of(n));
    end
    send_instr(1'b0, pad, a);
    oe_bad = 1'b0;
    for (int i = n * 8 - 1; i >= 0; i--) begin
      xfer_bit(val[i], smp);
      if (smp[2] || smp[0]) oe_bad = 1'b1;
    end
    chk(!oe_bad, "R7", "enables low in write data", DW'(oe_bad), '0);
  endtask

  task automatic do_read(input logic [1:0] pad, input logic [AW-1:0] a, input string req);
    int n, rc0;
    logic [3:0] smp;
    logic [DW-1:0] got, exp;
    bit oe_bad;
    n = nbytes_of(int'(a));
    rc0 = rd_cnt;
    send_instr(1'b1, pad, a);
    exp = (int'(a) < 6) ? (bmem[a[2:0]] & mask_of(n)) : '0;
    got = '0;
    oe_bad = 1'b0;
    for (int i = 0; i < n * 8; i++) begin
      xfer_bit(1'b0, smp);
      got = {got[DW-2:0], (two_wire ? smp[1] : smp[3])};
      if (two_wire) begin
        if (!(smp[0] && !smp[2])) oe_bad = 1'b1;
      end else begin
        if (!(smp[2] && !smp[0])) oe_bad = 1'b1;
      end
    end
    chk(got == exp, req, "read value", got, exp);
    chk(!oe_bad, two_wire ? "R6" : "R5", "read drive enables", DW'(oe_bad), '0);
    chk(rd_cnt == rc0 + 1, "R4", "one fetch strobe", DW'(rd_cnt - rc0), DW'(1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] smp;
    cs_n = 1'b1; sclk = 1'b0; sdio_i = 1'b0; two_wire = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!sdo_oe && !sdio_oe && !rf_wr_en && !rf_rd_en, "R7", "reset state",
        DW'({sdo_oe, sdio_oe, rf_wr_en, rf_rd_en}), '0);

    // R2 R3: each width, one transaction per frame, idle low, 3-wire
    frame_open(1'b0); do_write(2'b00, 5'd0, 48'hFFFF_1234_5678); frame_close(1'b0);
    frame_open(1'b0); do_write(2'b00, 5'd3, 48'hA1B2_C3D4_E5F6); frame_close(1'b0);
    frame_open(1'b0); do_write(2'b00, 5'd2, 48'h7777_009A_BCDE); frame_close(1'b0);
    frame_open(1'b0); do_write(2'b00, 5'd4, 48'h1111_2222_BEEF); frame_close(1'b0);
    // R8: two writes back to back in one frame
    frame_open(1'b0);
    do_write(2'b00, 5'd1, 48'h0000_CAFE_F00D);
    do_write(2'b00, 5'd5, 48'h0102_0304_0506);
    frame_close(1'b0);

    // R4 R5 R8: three reads in one frame, 3-wire, idle low
    frame_open(1'b0);
    do_read(2'b00, 5'd3, "R4");
    do_read(2'b00, 5'd0, "R8");
    do_read(2'b00, 5'd2, "R2");
    frame_close(1'b0);

    // R6 R10: 2-wire, clock idling high
    two_wire = 1'b1;
    frame_open(1'b1);
    do_read(2'b00, 5'd5, "R6");
    do_read(2'b00, 5'd1, "R10");
    frame_close(1'b1);
    frame_open(1'b1);
    do_write(2'b00, 5'd4, 48'h0000_0000_1357);
    do_read(2'b00, 5'd4, "R10");
    frame_close(1'b1);
    two_wire = 1'b0;

    // R1: bits 6:5 of the instruction have no effect
    frame_open(1'b0);
    do_write(2'b11, 5'd1, 48'h0000_7788_99AA);
    do_read(2'b10, 5'd1, "R1");
    frame_close(1'b0);

    // R11: unmapped read is zero and one byte long; unmapped write is dropped
    frame_open(1'b0);
    do_read(2'b00, 5'h1A, "R11");
    do_write(2'b00, 5'h10, 48'h0000_0000_005A);
    do_write(2'b00, 5'd4, 48'h0000_0000_2468);
    do_read(2'b00, 5'd4, "R11");
    frame_close(1'b0);

    // R9: abort a write mid-data; no commit, next frame starts fresh
    frame_open(1'b0);
    send_instr(1'b0, 2'b00, 5'd0);
    for (int i = 0; i < 13; i++) xfer_bit(1'b1, smp);
    frame_close(1'b0);
    frame_open(1'b0);
    do_read(2'b00, 5'd0, "R9");
    frame_close(1'b0);

    // R9 R7: abort a read mid-data; drivers release
    frame_open(1'b0);
    send_instr(1'b1, 2'b00, 5'd3);
    for (int i = 0; i < 4; i++) xfer_bit(1'b0, smp);
    sclk = 1'b0;
    repeat (H) @(negedge clk);
    chk(sdo_oe, "R5", "driving mid-read", DW'(sdo_oe), DW'(1));
    cs_n = 1'b1;
    repeat (H) @(negedge clk);
    chk(!sdo_oe && !sdio_oe, "R9", "release after abort", DW'({sdo_oe, sdio_oe}), '0);
    frame_open(1'b0);
    do_read(2'b00, 5'd2, "R9");
    frame_close(1'b0);

    repeat (20) @(negedge clk);
    chk(qa.size() == 0, "R3", "all commits seen", DW'(qa.size()), '0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule